// File: doc/BRIEF.md
# Delay-Window Offset Cancellation Controller

This block closes the digital side of an offset-cancelling loop in a bio-signal front end. A voltage-to-time stage upstream emits a start pulse and, some time later, a stop pulse. The distance between the two pulses, counted in reference-clock cycles, grows or shrinks with the residual DC offset at the electrodes. The controller times that distance and places it against a window made of four programmable thresholds. From the result it decides whether the correction must grow, shrink or stay where it is.

Each decision moves a saturating step counter by one unit. The counter drives 32 switch lines in thermometer code, so the current-steering converter downstream adds one fixed offset quantum per step. The window has hysteresis. Once a request starts it stays active until the delay has moved back past an inner threshold, so the loop does not chatter at the window edge. A settled flag tells the system when the loop has stopped stepping and the corrected signal can be used.

Top module: `offset_loop_ctrl`

## Requirements
- R1: The measured delay is the number of clock cycles from the cycle in which `tstart_i` is sampled high to the cycle in which `tstop_i` is sampled high. A stop pulse exactly k cycles after the start gives k. A further start pulse during a measurement is ignored.
- R2: If no stop pulse arrives, the delay count saturates at the all-ones value (255 with the default 8-bit width) and does not wrap. The saturated value is used when the stop pulse arrives.
- R3: A raise request begins when a measured delay is strictly greater than `thr_max_i`. It remains active for later measurements until a delay strictly less than `thr_hi_i` is measured.
- R4: A lower request begins when a measured delay is strictly less than `thr_min_i`. It remains active for later measurements until a delay strictly greater than `thr_lo_i` is measured.
- R5: The raise and lower requests are never active together. When one measurement would make both active, neither is issued and the step counter keeps its value.
- R6: The step counter changes at most once per completed measurement, by exactly one unit. A raise request adds one and a lower request subtracts one. It stays within 0 to 32 and saturates at both ends. The switch word reflects a measurement two clock cycles after the stop pulse is sampled.
- R7: `sw_word_o` is a thermometer code of the step count: count k drives bits 0 to k-1 high and every other bit low.
- R8: `settled_o` rises after `settle_n_i` consecutive measurements that carry no request. Any measurement that carries a raise or lower request clears it, even when the counter is already at its limit.
- R9: After reset, `sw_word_o` is all zeros, `settled_o` is low and no request is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tstart_i | input | 1 | Single-cycle pulse marking the start of the delay |
| tstop_i | input | 1 | Single-cycle pulse marking the end of the delay |
| thr_max_i | input | 8 | Outer upper delay threshold (starts a raise request) |
| thr_hi_i | input | 8 | Inner upper delay threshold (ends a raise request) |
| thr_min_i | input | 8 | Outer lower delay threshold (starts a lower request) |
| thr_lo_i | input | 8 | Inner lower delay threshold (ends a lower request) |
| settle_n_i | input | 4 | Number of quiet measurements needed before settled |
| sw_word_o | output | 32 | Thermometer-coded switch lines to the current converter |
| settled_o | output | 1 | High once the loop has stopped stepping |

## Verification
The two detectors can both fire on the same decision cycle. This happens when the thresholds are set so that one delay lies above the outer maximum and also below the outer minimum. The bench sets up exactly that case: it first holds a raise request, then crosses the thresholds and sends a delay that satisfies both start conditions. The result is judged at the switch word two cycles after the stop pulse, which must keep its earlier count. A second overlap is a request arriving in the same decision cycle as the quiet count that would set `settled_o`. It is provoked by sending a request right after a settled run, and it is judged by `settled_o` dropping while the count moves.

// File: rtl/ofc_pkg.sv
package ofc_pkg;

    // Phase of the delay timer
    typedef enum logic {
        MT_IDLE = 1'b0,
        MT_RUN  = 1'b1
    } mtr_state_e;

endpackage

// File: rtl/delay_meter.sv
module delay_meter
    import ofc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    output logic          done_o,
    output logic [DW-1:0] meas_o
);

    localparam logic [DW-1:0] CNT_MAX = {DW{1'b1}};

    typedef struct packed {
        mtr_state_e    st;
        logic [DW-1:0] cnt;
        logic          done;
        logic [DW-1:0] meas;
    } mtr_t;

    mtr_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            MT_IDLE: begin
                if (start_i) begin
                    d.st  = MT_RUN;
                    d.cnt = {{(DW-1){1'b0}}, 1'b1};
                end
            end
            MT_RUN: begin
                if (stop_i) begin
                    d.st   = MT_IDLE;
                    d.done = 1'b1;
                    d.meas = q.cnt;
                end else if (q.cnt != CNT_MAX) begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = MT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= MT_IDLE;
            q.cnt  <= '0;
            q.done <= 1'b0;
            q.meas <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign meas_o = q.meas;

    // R1: a completed measurement is reported for a single cycle only
    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R2: the running count never goes down while no stop pulse arrives
    a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == MT_RUN && !stop_i) |=> (q.cnt >= $past(q.cnt)));

endmodule

// File: rtl/window_ctrl.sv
module window_ctrl #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  logic [DW-1:0] meas_i,
    input  logic [DW-1:0] thr_max_i,
    input  logic [DW-1:0] thr_hi_i,
    input  logic [DW-1:0] thr_min_i,
    input  logic [DW-1:0] thr_lo_i,
    output logic          up_o,
    output logic          dn_o,
    output logic          evt_o
);

    typedef struct packed {
        logic up;
        logic dn;
        logic evt;
    } win_t;

    win_t q, d;
    logic up_next, dn_next;

    always_comb begin
        d       = q;
        d.evt   = done_i;
        up_next = q.up ? !(meas_i < thr_hi_i) : (meas_i > thr_max_i);
        dn_next = q.dn ? !(meas_i > thr_lo_i) : (meas_i < thr_min_i);
        if (done_i) begin
            if (up_next && dn_next) begin
                d.up = 1'b0;
                d.dn = 1'b0;
            end else begin
                d.up = up_next;
                d.dn = dn_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.up  <= 1'b0;
            q.dn  <= 1'b0;
            q.evt <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign up_o  = q.up;
    assign dn_o  = q.dn;
    assign evt_o = q.evt;

    // R5: raise and lower never active together
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.up && q.dn));

    // R3: a raise request only begins on a delay above the outer maximum
    a_r3_up_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.up) |-> ($past(meas_i) > $past(thr_max_i)));

    // R4: a lower request only begins on a delay below the outer minimum
    a_r4_dn_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.dn) |-> ($past(meas_i) < $past(thr_min_i)));

    // R3: request state is only re-evaluated on a completed measurement
    a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> ($stable(q.up) && $stable(q.dn)));

endmodule

// File: rtl/step_counter.sv
module step_counter #(
    parameter int SW_N = 32,
    parameter int STW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt_i,
    input  logic            up_i,
    input  logic            dn_i,
    input  logic [STW-1:0]  settle_n_i,
    output logic [SW_N-1:0] sw_o,
    output logic            settled_o
);

    localparam int              CW     = $clog2(SW_N + 1);
    localparam logic [CW-1:0]   TOP    = CW'(SW_N);
    localparam logic [STW-1:0]  QMAX   = {STW{1'b1}};

    typedef struct packed {
        logic [CW-1:0]  cnt;
        logic [STW-1:0] quiet;
        logic           settled;
    } stp_t;

    stp_t q, d;

    always_comb begin
        d = q;
        if (evt_i) begin
            if (up_i || dn_i) begin
                d.quiet   = '0;
                d.settled = 1'b0;
                if (up_i && q.cnt != TOP) begin
                    d.cnt = q.cnt + 1'b1;
                end else if (dn_i && q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end
            end else begin
                if (q.quiet != QMAX) begin
                    d.quiet = q.quiet + 1'b1;
                end
                d.settled = (d.quiet >= settle_n_i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cnt     <= '0;
            q.quiet   <= '0;
            q.settled <= 1'b0;
        end else begin
            q <= d;
        end
    end

    for (genvar i = 0; i < SW_N; i++) begin : g_thermo
        assign sw_o[i] = (q.cnt > CW'(i));
    end

    assign settled_o = q.settled;

    // R6: count stays within its range
    a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= TOP);

    // R6: count only moves after a decision
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_i |=> $stable(q.cnt));

    // R6: count moves by at most one unit per decision
    a_r6_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> ($stable(q.cnt) || (q.cnt == $past(q.cnt) + 1'b1)
                   || ($past(q.cnt) == q.cnt + 1'b1)));

    // R8: any request clears the settled flag
    a_r8_clear_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && (up_i || dn_i)) |=> !q.settled);

endmodule

// File: rtl/offset_loop_ctrl.sv
module offset_loop_ctrl #(
    parameter int DW   = 8,
    parameter int SW_N = 32,
    parameter int STW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tstart_i,
    input  logic            tstop_i,
    input  logic [DW-1:0]   thr_max_i,
    input  logic [DW-1:0]   thr_hi_i,
    input  logic [DW-1:0]   thr_min_i,
    input  logic [DW-1:0]   thr_lo_i,
    input  logic [STW-1:0]  settle_n_i,
    output logic [SW_N-1:0] sw_word_o,
    output logic            settled_o
);

    logic          done;
    logic [DW-1:0] meas;
    logic          up, dn, evt;

    delay_meter #(.DW(DW)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tstart_i),
        .stop_i  (tstop_i),
        .done_o  (done),
        .meas_o  (meas)
    );

    window_ctrl #(.DW(DW)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (done),
        .meas_i    (meas),
        .thr_max_i (thr_max_i),
        .thr_hi_i  (thr_hi_i),
        .thr_min_i (thr_min_i),
        .thr_lo_i  (thr_lo_i),
        .up_o      (up),
        .dn_o      (dn),
        .evt_o     (evt)
    );

    step_counter #(.SW_N(SW_N), .STW(STW)) u_steps (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .up_i       (up),
        .dn_i       (dn),
        .settle_n_i (settle_n_i),
        .sw_o       (sw_word_o),
        .settled_o  (settled_o)
    );

    // R7: switch lines always form a contiguous run from bit 0
    a_r7_thermo: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_word_o + 1'b1) & sw_word_o) == '0);

    // R9: nothing is requested or settled in the cycle after reset
    a_r9_reset_state: assert property (@(posedge clk)
        !rst_n |=> (sw_word_o == '0 && !settled_o));

endmodule

// File: tb/sim_offset_loop_ctrl.sv
module sim_offset_loop_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tstart = 1'b0, tstop = 1'b0;
    logic [7:0]  thr_max = 8'd40, thr_hi = 8'd30, thr_min = 8'd10, thr_lo = 8'd20;
    logic [3:0]  settle_n = 4'd3;
    logic [31:0] sw_word;
    logic        settled;

    int n_checks = 0;
    int n_fail   = 0;
    bit done_run = 0;

    always #5 clk = ~clk;

    offset_loop_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tstart_i   (tstart),
        .tstop_i    (tstop),
        .thr_max_i  (thr_max),
        .thr_hi_i   (thr_hi),
        .thr_min_i  (thr_min),
        .thr_lo_i   (thr_lo),
        .settle_n_i (settle_n),
        .sw_word_o  (sw_word),
        .settled_o  (settled)
    );

    // Table: delay, expected step count, expected settled
    localparam int NV = 11;
    localparam int VDLY [NV] = '{45, 35, 25, 35, 25, 25, 5, 15, 15, 25, 45};
    localparam int VCNT [NV] = '{ 1,  2,  2,  2,  2,  2, 1,  0,  0,  0,  1};
    localparam int VSET [NV] = '{ 0,  0,  0,  0,  1,  1, 0,  0,  0,  0,  0};

    function automatic logic [31:0] thermo(int k);
        logic [31:0] v = '0;
        for (int i = 0; i < 32; i++) v[i] = (i < k);
        return v;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Start sampled at edge E; stop sampled at edge E+d; ends just after E+d+2.
    task automatic measure(int d, int extra_start_at = -1);
        @(negedge clk);
        tstart = 1'b1;
        @(negedge clk);
        tstart = 1'b0;
        for (int c = 1; c < d; c++) begin
            tstart = (c == extra_start_at);
            @(negedge clk);
        end
        tstart = 1'b0;
        tstop  = 1'b1;
        @(negedge clk);
        tstop = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(sw_word == 32'h0, "R9 switch word", sw_word, 32'h0);
        check(settled == 1'b0, "R9 settled", {31'h0, settled}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R3 R4 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            measure(VDLY[v]);
            check(sw_word == thermo(VCNT[v]), "R3/R4/R6/R7 table count",
                  sw_word, thermo(VCNT[v]));
            check(settled == VSET[v][0], "R8 table settled",
                  {31'h0, settled}, {31'h0, VSET[v][0]});
        end

        // R5: crossed thresholds, raise held at count 1; delay 45 meets both starts
        thr_min = 8'd50;
        measure(45);
        check(sw_word == thermo(1), "R5 both conditions give no step", sw_word, thermo(1));
        thr_min = 8'd10;

        // R1: second start during measurement is ignored (would give 25 -> no step)
        measure(45, 20);
        check(sw_word == thermo(2), "R1 extra start ignored", sw_word, thermo(2));
        measure(25);
        check(sw_word == thermo(2), "R1 in-window delay holds count", sw_word, thermo(2));

        // R2: 270 cycles saturates at 255 (>40 gives a raise); wrap would give 14
        measure(270);
        check(sw_word == thermo(3), "R2 saturated delay raises", sw_word, thermo(3));
        measure(25);

        // R6: counter saturates at 32
        for (int k = 0; k < 32; k++) measure(45);
        check(sw_word == 32'hFFFF_FFFF, "R6 upper saturation", sw_word, 32'hFFFF_FFFF);
        check(settled == 1'b0, "R8 request at limit keeps settled low",
              {31'h0, settled}, 32'h0);

        // R1: exact delay at threshold edge: 41 > 40 raises from hold-clear state
        measure(25);
        measure(5);
        check(sw_word == thermo(31), "R6 single step down", sw_word, thermo(31));
        measure(25);
        measure(40);
        check(sw_word == thermo(31), "R1 delay 40 is not above max", sw_word, thermo(31));
        measure(41);
        check(sw_word == thermo(32), "R1 delay 41 is above max", sw_word, thermo(32));

        // R6: latency, switch word unchanged one cycle after stop, changed after two
        measure(25);
        measure(5);
        @(negedge clk); tstart = 1'b1;
        @(negedge clk); tstart = 1'b0;
        repeat (4) @(negedge clk);
        tstop = 1'b1;
        @(negedge clk); tstop = 1'b0;
        check(sw_word == thermo(31), "R6 no change one cycle after stop", sw_word, thermo(31));
        @(negedge clk);
        check(sw_word == thermo(31), "R6 no change two edges short", sw_word, thermo(31));
        @(negedge clk);
        check(sw_word == thermo(30), "R6 change after two cycles", sw_word, thermo(30));

        // R9: reset mid-run clears state
        rst_n = 1'b0;
        @(negedge clk);
        check(sw_word == 32'h0, "R9 reset clears count", sw_word, 32'h0);
        rst_n = 1'b1;
        done_run = 1;
    end

    initial begin
        fork
            wait (done_run);
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule